// File: doc/BRIEF.md
# Execute-in-Place Flash Read Cache

This block is a small read cache that sits between an instruction or data fetch port and a serial flash controller running in execute-in-place mode. Word reads that hit return from local storage one cycle after they are accepted. A read that misses starts a refill of the whole line. The refill sends the flash side one read command carrying the line-aligned start address. It then takes in a burst of consecutive incrementing bytes, one per valid strobe, until the line is full. The requested word is then returned.

The flash engine itself is outside this block. It is seen only as a command handshake followed by a byte stream. Three separate control events empty the cache: the module enable going low, the execute-in-place enable going low, and a one-cycle fence pulse. While the module is disabled, reads are answered at once with an error flag and never reach the flash.

Top module: `xip_rcache`

## Requirements
- R1: A miss raises exactly one flash command. Its address is the request address with the low log2(BLK_BYTES) bits cleared. The refill then takes exactly BLK_BYTES bytes, and each byte counts only in a cycle where fl_byte_valid_i is high.
- R2: Response words are little-endian. The byte at the word-aligned request address appears in rsp_data_o[7:0], and the byte at that address plus 3 appears in [31:24].
- R3: A hit sets rsp_valid_o in the cycle after the request is accepted and raises no flash command.
- R4: The cache is direct-mapped. The line index is req_addr_i[OFF_W+IDX_W-1:OFF_W], where OFF_W=log2(BLK_BYTES) and IDX_W=log2(NUM_LINES). A miss replaces only the line at that index, so lines at other indices still hit.
- R5: A fence_i pulse invalidates every line.
- R6: Every line is invalid while xip_en_i is low, and also after it returns high.
- R7: Every line is invalid while en_i is low, and also after it returns high.
- R8: A request accepted while en_i is low is answered in the next cycle with rsp_err_o=1 and raises no flash command.
- R9: If an invalidation event arrives during a refill, the refill still completes and returns correct data with rsp_err_o=0. The line is not left valid afterwards.
- R10: Each accepted request produces exactly one single-cycle response. req_ready_o stays low from the start of a miss until its response.
- R11: After reset, every line is invalid, req_ready_o=1, and rsp_valid_o and fl_cmd_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Module enable; low means reads get an error and lines are cleared |
| xip_en_i | input | 1 | Execute-in-place enable; low clears lines |
| fence_i | input | 1 | One-cycle pulse that clears all lines |
| req_valid_i | input | 1 | Word read request |
| req_addr_i | input | ADDR_W | Byte address of the word (word aligned) |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| rsp_valid_o | output | 1 | Response strobe, one cycle |
| rsp_data_o | output | 32 | Read word, little-endian |
| rsp_err_o | output | 1 | Request was refused because module is disabled |
| fl_cmd_valid_o | output | 1 | Flash burst read command request |
| fl_cmd_addr_o | output | ADDR_W | Line-aligned burst start address |
| fl_cmd_ready_i | input | 1 | Flash engine accepts the command |
| fl_byte_valid_i | input | 1 | Burst byte present |
| fl_byte_i | input | 8 | Burst byte, ascending address order |

## Verification
The checks assume three things about the flash side. It sends no bytes before it accepts a command. It sends exactly one line's worth of bytes per command. It keeps its byte strobe low between bursts. The bench flash model does this: it starts streaming only on the cycle after it sees a command and stops after BLK_BYTES bytes. Requests are assumed to be word aligned and are raised only while req_ready_o is high, and every stimulus address meets both conditions.

// File: rtl/xip_rcache_pkg.sv
package xip_rcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_FILL = 2'd2,
    ST_RESP = 2'd3
  } ctrl_state_e;
endpackage

// File: rtl/xip_rcache_tags.sv
module xip_rcache_tags #(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 16,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all_i,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic [IDX_W-1:0] look_idx_i,
  input  logic [TAG_W-1:0] look_tag_i,
  output logic             hit_o,
  output logic [NUM_LINES-1:0] valid_o
);
  logic [NUM_LINES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_line
      always_comb begin
        valid_d[g] = valid_q[g];
        if (set_i && set_idx_i == IDX_W'(g)) valid_d[g] = 1'b1;
        if (clr_all_i) valid_d[g] = 1'b0;
      end
      always_ff @(posedge clk) begin
        if (set_i && set_idx_i == IDX_W'(g)) tag_q[g] <= set_tag_i;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  assign hit_o   = valid_q[look_idx_i] && (tag_q[look_idx_i] == look_tag_i);
  assign valid_o = valid_q;
endmodule

// File: rtl/xip_rcache_bytes.sv
module xip_rcache_bytes #(
  parameter int NUM_LINES = 4,
  parameter int BLK_BYTES = 8,
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam int DEPTH    = NUM_LINES * BLK_BYTES
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [IDX_W-1:0] w_idx_i,
  input  logic [OFF_W-1:0] w_off_i,
  input  logic [7:0]       w_byte_i,
  input  logic [IDX_W-1:0] r_idx_i,
  input  logic [OFF_W-1:0] r_off_i,
  output logic [31:0]      r_word_o
);
  logic [7:0] mem_q [DEPTH];
  logic [OFF_W-1:0] base_off;

  always_ff @(posedge clk) begin
    if (we_i) mem_q[{w_idx_i, w_off_i}] <= w_byte_i;
  end

  assign base_off = r_off_i & ~OFF_W'(3);

  genvar b;
  generate
    for (b = 0; b < 4; b++) begin : g_lane
      assign r_word_o[8*b +: 8] = mem_q[{r_idx_i, base_off + OFF_W'(b)}];
    end
  endgenerate
endmodule

// File: rtl/xip_rcache_ctrl.sv
module xip_rcache_ctrl
  import xip_rcache_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BLK_BYTES = 8,
  localparam int OFF_W    = $clog2(BLK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              inv_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic [ADDR_W-1:0] look_addr_o,
  input  logic              hit_i,
  input  logic [31:0]       word_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_data_o,
  output logic              rsp_err_o,
  output logic              fl_cmd_valid_o,
  output logic [ADDR_W-1:0] fl_cmd_addr_o,
  input  logic              fl_cmd_ready_i,
  input  logic              fl_byte_valid_i,
  output logic              wr_en_o,
  output logic [OFF_W-1:0]  wr_off_o,
  output logic              set_valid_o,
  output logic [ADDR_W-1:0] fill_addr_o
);
  ctrl_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic              kill_q, kill_d;
  logic              rv_q, rv_d, re_q, re_d;
  logic [31:0]       rd_q, rd_d;
  logic              last_byte;

  assign last_byte = (state_q == ST_FILL) && fl_byte_valid_i && (cnt_q == OFF_W'(BLK_BYTES - 1));

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    kill_d  = kill_q;
    rv_d    = 1'b0;
    re_d    = 1'b0;
    rd_d    = rd_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          if (!en_i) begin
            rv_d = 1'b1;
            re_d = 1'b1;
            rd_d = '0;
          end else if (hit_i && !inv_i) begin
            rv_d = 1'b1;
            rd_d = word_i;
          end else begin
            state_d = ST_CMD;
            addr_d  = req_addr_i;
            kill_d  = 1'b0;
          end
        end
      end
      ST_CMD: begin
        kill_d = kill_q | inv_i;
        if (fl_cmd_ready_i) begin
          state_d = ST_FILL;
          cnt_d   = '0;
        end
      end
      ST_FILL: begin
        kill_d = kill_q | inv_i;
        if (fl_byte_valid_i) begin
          cnt_d = cnt_q + OFF_W'(1);
          if (last_byte) state_d = ST_RESP;
        end
      end
      default: begin
        rv_d    = 1'b1;
        rd_d    = word_i;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      kill_q  <= 1'b0;
      rv_q    <= 1'b0;
      re_q    <= 1'b0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      kill_q  <= kill_d;
      rv_q    <= rv_d;
      re_q    <= re_d;
      rd_q    <= rd_d;
    end
  end

  assign req_ready_o    = (state_q == ST_IDLE);
  assign look_addr_o    = (state_q == ST_IDLE) ? req_addr_i : addr_q;
  assign rsp_valid_o    = rv_q;
  assign rsp_err_o      = re_q;
  assign rsp_data_o     = rd_q;
  assign fl_cmd_valid_o = (state_q == ST_CMD);
  assign fl_cmd_addr_o  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign wr_en_o        = (state_q == ST_FILL) && fl_byte_valid_i;
  assign wr_off_o       = cnt_q;
  assign set_valid_o    = last_byte && !kill_q && !inv_i;
  assign fill_addr_o    = addr_q;
endmodule

// File: rtl/xip_rcache.sv
module xip_rcache #(
  parameter int ADDR_W    = 24,
  parameter int BLK_BYTES = 8,
  parameter int NUM_LINES = 4,
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              xip_en_i,
  input  logic              fence_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_data_o,
  output logic              rsp_err_o,
  output logic              fl_cmd_valid_o,
  output logic [ADDR_W-1:0] fl_cmd_addr_o,
  input  logic              fl_cmd_ready_i,
  input  logic              fl_byte_valid_i,
  input  logic [7:0]        fl_byte_i
);
  logic              inv_all;
  logic [ADDR_W-1:0] look_addr, fill_addr;
  logic              hit, wr_en, set_valid;
  logic [OFF_W-1:0]  wr_off;
  logic [31:0]       word;
  logic [NUM_LINES-1:0] line_valid;

  assign inv_all = !en_i || !xip_en_i || fence_i;

  xip_rcache_ctrl #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .inv_i(inv_all),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .req_ready_o(req_ready_o),
    .look_addr_o(look_addr), .hit_i(hit), .word_i(word),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o), .rsp_err_o(rsp_err_o),
    .fl_cmd_valid_o(fl_cmd_valid_o), .fl_cmd_addr_o(fl_cmd_addr_o),
    .fl_cmd_ready_i(fl_cmd_ready_i), .fl_byte_valid_i(fl_byte_valid_i),
    .wr_en_o(wr_en), .wr_off_o(wr_off), .set_valid_o(set_valid), .fill_addr_o(fill_addr)
  );

  xip_rcache_tags #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .clr_all_i(inv_all), .set_i(set_valid),
    .set_idx_i(fill_addr[OFF_W +: IDX_W]), .set_tag_i(fill_addr[ADDR_W-1 -: TAG_W]),
    .look_idx_i(look_addr[OFF_W +: IDX_W]), .look_tag_i(look_addr[ADDR_W-1 -: TAG_W]),
    .hit_o(hit), .valid_o(line_valid)
  );

  xip_rcache_bytes #(.NUM_LINES(NUM_LINES), .BLK_BYTES(BLK_BYTES)) u_bytes (
    .clk(clk), .we_i(wr_en), .w_idx_i(fill_addr[OFF_W +: IDX_W]), .w_off_i(wr_off),
    .w_byte_i(fl_byte_i), .r_idx_i(look_addr[OFF_W +: IDX_W]),
    .r_off_i(look_addr[OFF_W-1:0]), .r_word_o(word)
  );
endmodule

// File: rtl/xip_rcache_chk.sv
module xip_rcache_chk #(
  parameter int ADDR_W    = 24,
  parameter int BLK_BYTES = 8,
  parameter int NUM_LINES = 4,
  localparam int OFF_W    = $clog2(BLK_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              xip_en_i,
  input logic              fence_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_err_o,
  input logic              fl_cmd_valid_o,
  input logic [ADDR_W-1:0] fl_cmd_addr_o,
  input logic              fl_cmd_ready_i,
  input logic [NUM_LINES-1:0] line_valid
);
  AST_CMD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cmd_valid_o |-> fl_cmd_addr_o[OFF_W-1:0] == '0); // R1
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cmd_valid_o && !fl_cmd_ready_i) |=> (fl_cmd_valid_o && $stable(fl_cmd_addr_o))); // R1
  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cmd_valid_o && fl_cmd_ready_i) |=> !fl_cmd_valid_o); // R1
  AST_FENCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    fence_i |=> (line_valid == '0)); // R5
  AST_XIP_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !xip_en_i |=> (line_valid == '0)); // R6
  AST_EN_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (line_valid == '0)); // R7
  AST_DISABLED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && !en_i) |=> (rsp_valid_o && rsp_err_o)); // R8
  AST_ERR_ONLY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_err_o) |-> !$past(en_i)); // R8
  AST_BUSY_NO_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> !fl_cmd_valid_o); // R10
endmodule

bind xip_rcache xip_rcache_chk #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .xip_en_i(xip_en_i), .fence_i(fence_i),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
  .rsp_err_o(rsp_err_o), .fl_cmd_valid_o(fl_cmd_valid_o), .fl_cmd_addr_o(fl_cmd_addr_o),
  .fl_cmd_ready_i(fl_cmd_ready_i), .line_valid(line_valid)
);

// File: tb/xip_rcache_tb.sv
`timescale 1ns/1ps
module xip_rcache_tb;
  localparam int AW  = 24;
  localparam int BLK = 8;

  logic clk, rst_n, en, xip_en, fence, req_valid;
  logic [AW-1:0] req_addr;
  logic req_ready, rsp_valid, rsp_err, fl_cmd_valid, fl_cmd_ready, fl_byte_valid;
  logic [31:0] rsp_data;
  logic [AW-1:0] fl_cmd_addr;
  logic [7:0] fl_byte;

  int errors = 0, checks = 0;
  int cmd_cnt = 0, rem = 0;
  logic [AW-1:0] ptr, last_cmd;

  xip_rcache #(.ADDR_W(AW), .BLK_BYTES(BLK), .NUM_LINES(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .xip_en_i(xip_en), .fence_i(fence),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_err_o(rsp_err),
    .fl_cmd_valid_o(fl_cmd_valid), .fl_cmd_addr_o(fl_cmd_addr), .fl_cmd_ready_i(fl_cmd_ready),
    .fl_byte_valid_i(fl_byte_valid), .fl_byte_i(fl_byte)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] fb(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] exp_word(input logic [AW-1:0] a);
    return {fb(a + 3), fb(a + 2), fb(a + 1), fb(a)};
  endfunction

  // flash byte-stream model
  always @(negedge clk) begin
    if (rem > 0) begin
      fl_byte_valid = 1'b1;
      fl_byte = fb(ptr);
      ptr = ptr + 1;
      rem = rem - 1;
    end else begin
      fl_byte_valid = 1'b0;
    end
    if (rst_n && fl_cmd_valid && rem == 0) begin
      cmd_cnt  = cmd_cnt + 1;
      last_cmd = fl_cmd_addr;
      ptr      = fl_cmd_addr;
      rem      = BLK;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] d;
  logic e, busy;
  int waits, ncmd;

  task automatic do_read(input logic [AW-1:0] a, input int fcyc);
    int c0;
    c0 = cmd_cnt;
    busy = 1'b0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    waits = 1;
    while (!rsp_valid && waits < 200) begin
      if (!req_ready) busy = 1'b1;
      fence = (waits == fcyc);
      @(negedge clk);
      waits++;
    end
    fence = 1'b0;
    d = rsp_data;
    e = rsp_err;
    ncmd = cmd_cnt - c0;
    @(negedge clk);
    check(!rsp_valid, "R10 single-cycle response", 32'(rsp_valid), 0);
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R11 req_ready after reset", 32'(req_ready), 1);
    check(rsp_valid == 1'b0, "R11 rsp_valid after reset", 32'(rsp_valid), 0);
    check(fl_cmd_valid == 1'b0, "R11 cmd idle after reset", 32'(fl_cmd_valid), 0);
    do_read(24'h000104, 0);
    check(ncmd == 1, "R11 first read misses", 32'(ncmd), 1);
  endtask

  task automatic t_miss_hit();
    fence = 1'b1; @(negedge clk); fence = 1'b0;
    do_read(24'h00010C, 0);
    check(ncmd == 1, "R1 one command per miss", 32'(ncmd), 1);
    check(last_cmd == 24'h000108, "R1 aligned burst address", 32'(last_cmd), 32'h108);
    check(d == exp_word(24'h00010C), "R2 little-endian refill data", d, exp_word(24'h00010C));
    check(e == 1'b0, "R1 no error on miss", 32'(e), 0);
    check(busy == 1'b1, "R10 ready low during miss", 32'(busy), 1);
    do_read(24'h000108, 0);
    check(ncmd == 0, "R3 hit raises no command", 32'(ncmd), 0);
    check(waits == 1, "R3 hit latency one cycle", 32'(waits), 1);
    check(d == exp_word(24'h000108), "R3 hit data", d, exp_word(24'h000108));
  endtask

  task automatic t_conflict();
    do_read(24'h000100, 0);
    check(ncmd == 1, "R4 line 0 fill", 32'(ncmd), 1);
    do_read(24'h000120, 0);
    check(ncmd == 1 && d == exp_word(24'h000120), "R4 conflicting tag misses", 32'(ncmd), 1);
    do_read(24'h00010C, 0);
    check(ncmd == 0, "R4 other index still hits", 32'(ncmd), 0);
    do_read(24'h000104, 0);
    check(ncmd == 1 && d == exp_word(24'h000104), "R4 evicted line misses", 32'(ncmd), 1);
  endtask

  task automatic t_fence();
    do_read(24'h000104, 0);
    check(ncmd == 0, "R5 hit before fence", 32'(ncmd), 0);
    fence = 1'b1; @(negedge clk); fence = 1'b0; @(negedge clk);
    do_read(24'h000104, 0);
    check(ncmd == 1, "R5 miss after fence", 32'(ncmd), 1);
  endtask

  task automatic t_xip_off();
    xip_en = 1'b0;
    do_read(24'h000104, 0);
    check(ncmd == 1, "R6 miss with xip off", 32'(ncmd), 1);
    do_read(24'h000104, 0);
    check(ncmd == 1 && d == exp_word(24'h000104), "R6 no retention with xip off", 32'(ncmd), 1);
    xip_en = 1'b1; @(negedge clk);
    do_read(24'h000104, 0);
    check(ncmd == 1, "R6 miss after xip re-enable", 32'(ncmd), 1);
  endtask

  task automatic t_disable();
    do_read(24'h000104, 0);
    check(ncmd == 0, "R7 hit before disable", 32'(ncmd), 0);
    en = 1'b0;
    do_read(24'h000104, 0);
    check(e == 1'b1, "R8 error when disabled", 32'(e), 1);
    check(ncmd == 0, "R8 no command when disabled", 32'(ncmd), 0);
    check(waits == 1, "R8 error latency", 32'(waits), 1);
    en = 1'b1; @(negedge clk);
    do_read(24'h000104, 0);
    check(ncmd == 1 && e == 1'b0, "R7 miss after re-enable", 32'(ncmd), 1);
  endtask

  task automatic t_fence_in_fill();
    do_read(24'h000140, 5);
    check(ncmd == 1, "R9 fill proceeds", 32'(ncmd), 1);
    check(d == exp_word(24'h000140) && e == 1'b0, "R9 data despite fence", d, exp_word(24'h000140));
    do_read(24'h000144, 0);
    check(ncmd == 1, "R9 line not kept valid", 32'(ncmd), 1);
    do_read(24'h000144, 0);
    check(ncmd == 0, "R9 normal refill then hits", 32'(ncmd), 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; xip_en = 1'b1; fence = 1'b0;
    req_valid = 1'b0; req_addr = '0; fl_cmd_ready = 1'b1;
    fl_byte_valid = 1'b0; fl_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss_hit();
    t_conflict();
    t_fence();
    t_xip_off();
    t_disable();
    t_fence_in_fill();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule